// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This block is the timer unit of a processor core. It holds a 64-bit time base that counts up and a 32-bit decrementer that counts down. Both move by one on a shared tick enable, which an internal prescaler derives from the core clock at a ratio set by a parameter. When the decrementer counts down past zero, the block raises a level timer interrupt and the decrementer carries on from all ones without missing a tick.

Software reaches the unit through a simple register port. There is a one-cycle write strobe with a select and data, and a registered read path. Each half of the time base can be written without disturbing the other half. A decrementer write also raises the interrupt when the new value is negative and the old value was not, which follows the two's-complement view of the count. The interrupt stays asserted until the core pulses a write-one-to-clear acknowledge.

Top module: `tbdec_timer`

## Requirements
- R1: After synchronous reset the time base reads 0, the decrementer reads 0xFFFFFFFF and `irq` is low.
- R2: The tick enable fires once every TICK_DIV core cycles. On each tick, the 64-bit time base goes up by one and the decrementer goes down by one.
- R3: When the lower time-base half wraps from 0xFFFFFFFF to 0, the upper half goes up by one on the same clock edge.
- R4: A write with select 0 loads the lower time-base half and keeps the present upper half. A write with select 1 loads the upper half and keeps the present lower half.
- R5: A tick that finds the decrementer at 0 sets `irq` and leaves the decrementer at 0xFFFFFFFF. Later ticks keep counting down from there.
- R6: Writing 0 to the decrementer (select 2) does not signal expiry by itself. Expiry comes on the first tick after the write.
- R7: A decrementer write sets `irq` when bit 31 of the new value is 1 and bit 31 of the current value is 0. Any other decrementer write leaves `irq` as it was.
- R8: Once set, `irq` stays high until a cycle with `irq_ack` high clears it. If an expiry or a raising write falls in the same cycle as the acknowledge, `irq` stays set.
- R9: If a register write and a tick fall on the same cycle, the written register takes the written value and ignores that tick. The other counter still advances.
- R10: `rd_data` shows, one cycle later, the register chosen by `rd_sel` as it stood at the sampling edge: 0 for the lower half, 1 for the upper half, 2 for the decrementer. Select 3 reads as 0, and a write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sel | input | 2 | Write target: 0 lower half, 1 upper half, 2 decrementer, 3 none |
| wr_data | input | HALF_W | Write data |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | HALF_W | Registered read data |
| irq_ack | input | 1 | Write-one-to-clear acknowledge for the interrupt |
| irq | output | 1 | Level timer interrupt |

## Verification
Each result is due at the clock edge that first sees its cause. Counter and interrupt changes appear at the edge where the tick, write or acknowledge is sampled, and a read shows the state from before that same edge. The bench applies inputs on the falling edge and advances a reference model at the next rising edge. It compares `rd_data` and `irq` at the falling edge that follows. No result is ever looked for earlier or later than the edge the requirements give. The sweeps cover every prescaler phase for collisions between writes and ticks, a range of small decrementer loads, and lower-half values near the wrap.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;
  // Register select encoding shared by the read and write paths
  typedef enum logic [1:0] {
    SEL_TB_LO = 2'd0,
    SEL_TB_HI = 2'd1,
    SEL_DEC   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tbdec_prescaler.sv
module tbdec_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt;
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);

      always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end

      assign tick = (cnt == LAST);

      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tbdec_timebase.sv
module tbdec_timebase #(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [HALF_W-1:0]     wdata,
  output logic [2*HALF_W-1:0]   tb
);
  localparam int TB_W = 2 * HALF_W;

  always_ff @(posedge clk) begin
    if (rst)        tb <= '0;
    else if (wr_lo) tb[HALF_W-1:0] <= wdata;
    else if (wr_hi) tb[TB_W-1:HALF_W] <= wdata;
    else if (tick)  tb <= tb + TB_W'(1);
  end

  // R2 R3
  tb_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_lo && !wr_hi) |=> tb == $past(tb) + TB_W'(1));

  // R4
  lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (tb[TB_W-1:HALF_W] == $past(tb[TB_W-1:HALF_W])) &&
              (tb[HALF_W-1:0] == $past(wdata)));

  // R4
  hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> (tb[HALF_W-1:0] == $past(tb[HALF_W-1:0])) &&
                          (tb[TB_W-1:HALF_W] == $past(wdata)));
endmodule

// File: rtl/tbdec_decrementer.sv
module tbdec_decrementer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         ack,
  output logic [W-1:0] dec,
  output logic         irq
);
  logic expire;
  logic sw_raise;

  // Expiry: a tick finds the count at zero and no write overrides it
  assign expire   = tick && !wr && (dec == '0);
  // Sign transition from non-negative to negative by a write
  assign sw_raise = wr && wdata[W-1] && !dec[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      dec <= '1;
      irq <= 1'b0;
    end else begin
      if (wr)        dec <= wdata;
      else if (tick) dec <= dec - 1'b1;

      if (expire || sw_raise) irq <= 1'b1;
      else if (ack)           irq <= 1'b0;
    end
  end

  // R5
  expire_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr && dec == '0) |=> (dec == '1) && irq);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack) |=> irq);

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> dec == $past(wdata));

  // R7
  sw_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[W-1] && !dec[W-1]) |=> irq);
endmodule

// File: rtl/tbdec_timer.sv
module tbdec_timer #(
  parameter int HALF_W   = 32,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [HALF_W-1:0] rd_data,
  input  logic              irq_ack,
  output logic              irq
);
  import tbdec_pkg::*;

  localparam int TB_W = 2 * HALF_W;

  logic              tick;
  logic              wr_lo, wr_hi, wr_dec;
  logic [TB_W-1:0]   tb;
  logic [HALF_W-1:0] dec;

  assign wr_lo  = wr_en && (reg_sel_e'(wr_sel) == SEL_TB_LO);
  assign wr_hi  = wr_en && (reg_sel_e'(wr_sel) == SEL_TB_HI);
  assign wr_dec = wr_en && (reg_sel_e'(wr_sel) == SEL_DEC);

  tbdec_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  tbdec_timebase #(.HALF_W(HALF_W)) u_tb (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (wr_data),
    .tb    (tb)
  );

  tbdec_decrementer #(.W(HALF_W)) u_dec (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .wr    (wr_dec),
    .wdata (wr_data),
    .ack   (irq_ack),
    .dec   (dec),
    .irq   (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (reg_sel_e'(rd_sel))
        SEL_TB_LO: rd_data <= tb[HALF_W-1:0];
        SEL_TB_HI: rd_data <= tb[TB_W-1:HALF_W];
        SEL_DEC:   rd_data <= dec;
        default:   rd_data <= '0;
      endcase
    end
  end

  // R10
  none_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == 2'd3) |=> rd_data == '0);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!irq && rd_data == '0));
endmodule

// File: tb/tbdec_timer_bench.sv
module tbdec_timer_bench;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic        irq_ack = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state, built from the requirements
  int          m_cnt;
  logic [63:0] m_tb;
  logic [31:0] m_dec;
  logic        m_irq;
  logic [31:0] m_rd;

  always #10 clk = ~clk;

  tbdec_timer #(.HALF_W(32), .TICK_DIV(DIV)) u_tbdec_timer (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .irq_ack (irq_ack),
    .irq     (irq)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic step(bit we, logic [1:0] ws, logic [31:0] wd,
                      logic [1:0] rs, bit ack, string tag);
    bit mt;
    bit set;
    wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs; irq_ack = ack;
    @(posedge clk);
    mt = (m_cnt == DIV - 1);
    case (rs)
      2'd0: m_rd = m_tb[31:0];
      2'd1: m_rd = m_tb[63:32];
      2'd2: m_rd = m_dec;
      default: m_rd = 32'd0;
    endcase
    set = 1'b0;
    if (we && ws == 2'd2) begin
      if (wd[31] && !m_dec[31]) set = 1'b1;
      m_dec = wd;
    end else if (mt) begin
      if (m_dec == 32'd0) set = 1'b1;
      m_dec = m_dec - 32'd1;
    end
    if (we && ws == 2'd0)      m_tb[31:0]  = wd;
    else if (we && ws == 2'd1) m_tb[63:32] = wd;
    else if (mt)               m_tb = m_tb + 64'd1;
    if (set)      m_irq = 1'b1;
    else if (ack) m_irq = 1'b0;
    m_cnt = mt ? 0 : m_cnt + 1;
    @(negedge clk);
    chk(tag, "rd_data", rd_data, m_rd);
    chk(tag, "irq", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic idle(int n, logic [1:0] rs, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0, rs, 1'b0, tag);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_tb = 64'd0; m_dec = 32'hFFFF_FFFF; m_irq = 1'b0; m_rd = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset values, explicit constants
    step(1'b0, 2'd2, 32'd0, 2'd2, 1'b0, "R1");
    chk("R1", "dec after reset", rd_data, 32'hFFFF_FFFF);
    chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
    step(1'b0, 2'd0, 32'd0, 2'd1, 1'b0, "R1");
    chk("R1", "tb hi after reset", rd_data, 32'd0);

    // R2: free counting, read each register in turn
    for (int i = 0; i < 4 * DIV; i++) step(1'b0, 2'd0, 32'd0, 2'(i % 3), 1'b0, "R2");

    // R3: lower half near the wrap, several start points and upper values
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 2'd1, 32'h1234_0000 + k, 2'd0, 1'b0, "R4");
      step(1'b1, 2'd0, 32'hFFFF_FFFF - k, 2'd1, 1'b0, "R4");
      for (int i = 0; i < (k + 2) * DIV; i++) step(1'b0, 2'd0, 32'd0, 2'(i % 2), 1'b0, "R3");
    end

    // R9: write lower half / decrementer at every prescaler phase
    for (int p = 0; p < DIV; p++) begin
      step(1'b1, 2'd0, 32'hA5A5_0000 + p, 2'd0, 1'b0, "R9");
      step(1'b0, 2'd0, 32'd0, 2'd0, 1'b0, "R9");
      step(1'b1, 2'd2, 32'h0000_0100 + p, 2'd2, 1'b0, "R9");
      step(1'b0, 2'd0, 32'd0, 2'd2, 1'b0, "R9");
      step(1'b0, 2'd0, 32'd0, 2'd1, 1'b0, "R9");
    end

    // R10: select 3 reads zero and writes nothing
    step(1'b1, 2'd3, 32'hDEAD_BEEF, 2'd3, 1'b0, "R10");
    step(1'b0, 2'd0, 32'd0, 2'd0, 1'b0, "R10");
    step(1'b0, 2'd0, 32'd0, 2'd1, 1'b0, "R10");
    step(1'b0, 2'd0, 32'd0, 2'd2, 1'b0, "R10");

    // R5 R6: small decrementer loads including zero, each at a fresh phase
    for (int v = 0; v < 7; v++) begin
      step(1'b1, 2'd2, 32'(v), 2'd2, 1'b0, "R6");
      idle((v + 2) * DIV + 1, 2'd2, "R5");
      step(1'b0, 2'd0, 32'd0, 2'd2, 1'b1, "R8");
      step(1'b0, 2'd0, 32'd0, 2'd2, 1'b0, "R8");
    end

    // R7: negative write over positive raises; over negative does not
    step(1'b1, 2'd2, 32'h0000_0050, 2'd2, 1'b0, "R7");
    step(1'b1, 2'd2, 32'h8000_0000, 2'd2, 1'b0, "R7");
    step(1'b0, 2'd0, 32'd0, 2'd2, 1'b1, "R7");
    step(1'b1, 2'd2, 32'hC000_0000, 2'd2, 1'b0, "R7");
    step(1'b1, 2'd2, 32'h7FFF_FFFF, 2'd2, 1'b0, "R7");
    idle(2, 2'd2, "R7");

    // R8: acknowledge held across an expiry; the expiry wins
    step(1'b1, 2'd2, 32'd1, 2'd2, 1'b0, "R8");
    for (int i = 0; i < 3 * DIV + 2; i++) step(1'b0, 2'd0, 32'd0, 2'd2, 1'b1, "R8");
    step(1'b0, 2'd0, 32'd0, 2'd2, 1'b0, "R8");
    step(1'b0, 2'd0, 32'd0, 2'd2, 1'b1, "R8");
    // raising write coincident with acknowledge
    step(1'b1, 2'd2, 32'h0000_0010, 2'd2, 1'b0, "R8");
    step(1'b1, 2'd2, 32'h9000_0000, 2'd2, 1'b1, "R8");
    idle(3, 2'd2, "R8");

    summary();
    done = 1'b1;
    $finish;
  end
endmodule